// File: doc/BRIEF.md
# Half-Word Multiply-Add Execution Unit

This unit executes one integer multiply-add instruction per clock, working on 16-bit halves of its sources. Each instruction arrives as a valid-qualified 64-bit word in the immediate-operand form. It comes together with the 32-bit values already read from the register file for the A and C operands. The unit decodes the control fields and picks one 16-bit half of A. It takes the 16-bit immediate as B and widens each operand with sign or zero fill. It multiplies them, may shift the product up by 16 bits, and adds an addend derived from C or from B. It may then overwrite the upper half of the sum with B.

The unit is a two-stage pipeline. The first stage decodes, extends and multiplies. The second stage shifts, adds and merges. Each result leaves on a registered output beat. The beat carries the destination register index, the 32-bit result, a write enable and a flag for unsupported encodings. The register file reads these outputs. Operand fetch and the other operand forms are outside the unit.

Top module: `hmad_unit`

## Requirements
- R1: The destination index on the output beat equals instruction bits 7:0 of the instruction that produced it.
- R2: Bit 53 picks the A half: 0 takes A bits 15:0 and 1 takes A bits 31:16. Bit 48 set sign-extends that half to 32 bits, and clear zero-extends it.
- R3: B is the immediate at instruction bits 35:20. Bit 49 set sign-extends it to 32 bits, and clear zero-extends it.
- R4: The product is the low 32 bits of extended A times extended B. When bit 36 is set, the product is shifted left by 16 before the addition.
- R5: The addend is chosen by bits 52:50. Code 0 gives all of C. Code 1 gives C bits 15:0 zero-extended. Code 2 gives C bits 31:16 zero-extended. Code 4 gives B in both halves, {B,B}. The result is the product plus the addend, modulo 2^32.
- R6: When bit 37 is set, result bits 31:16 are replaced by B and result bits 15:0 are kept.
- R7: Some encodings are unsupported: bit 38 set, bit 47 set, or addend code 3, 5, 6 or 7. Such an instruction still produces an output beat, with the unsupported flag at 1 and the write enable at 0. A supported instruction gives the flag at 0 and the write enable at 1. The result value of an unsupported beat is not defined.
- R8: The output beat of an instruction accepted at a clock edge appears after the second following edge. A new instruction can be accepted at every edge, and out_valid is low in cycles with no beat.
- R9: A synchronous active-high reset clears every pipeline valid bit, so no beat leaves during or directly after reset. This holds even when in_valid was high before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| in_insn | input | 64 | Immediate-form instruction word |
| in_a | input | 32 | Value read for register operand A |
| in_c | input | 32 | Value read for register operand C |
| out_valid | output | 1 | Output beat present |
| out_dst | output | 8 | Destination register index |
| out_result | output | 32 | Result value |
| out_wr_en | output | 1 | Write the result to the destination register |
| out_unsup | output | 1 | Instruction used an unsupported encoding |

## Verification
Some directed operands have the top bit of the chosen half set. These tell sign fill from zero fill for each source independently. A is loaded with different patterns in its two halves, which shows which half was picked. The operands also show whether the product was truncated to 32 bits or shifted. The same C value is used with each addend code, so every code yields a distinct sum. Merge is tried with and without the shift. Unsupported encodings, back-to-back beats with gaps, and a reset taken while instructions are in flight check the flag and the valid pipeline. A long stretch of pseudo-random words then mixes all fields, and each beat is compared with a behavioural model.

// File: rtl/hmad_pkg.sv
package hmad_pkg;

  localparam int INSN_W = 64;
  localparam int DATA_W = 32;
  localparam int HALF_W = 16;
  localparam int REG_W  = 8;

  // instruction field positions (decoded by this unit)
  localparam int F_DST    = 0;
  localparam int F_IMM    = 20;
  localparam int F_SHL    = 36;
  localparam int F_MRG    = 37;
  localparam int F_EXT    = 38;
  localparam int F_CC     = 47;
  localparam int F_ASGN   = 48;
  localparam int F_BSGN   = 49;
  localparam int F_CSEL   = 50;
  localparam int CSEL_W   = 3;
  localparam int F_AHI    = 53;

  typedef enum logic [CSEL_W-1:0] {
    CSEL_FULL = 3'd0,
    CSEL_LOW  = 3'd1,
    CSEL_HIGH = 3'd2,
    CSEL_RSV3 = 3'd3,
    CSEL_BB   = 3'd4,
    CSEL_RSV5 = 3'd5,
    CSEL_RSV6 = 3'd6,
    CSEL_RSV7 = 3'd7
  } csel_e;

  typedef struct packed {
    logic [REG_W-1:0]  dst;
    logic [HALF_W-1:0] imm;
    logic              a_hi;
    logic              a_sgn;
    logic              b_sgn;
    logic              shl;
    logic              mrg;
    logic              unsup;
    csel_e             csel;
  } ctl_t;

endpackage

// File: rtl/hmad_decode.sv
module hmad_decode
  import hmad_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output ctl_t              ctl
);

  csel_e sel;
  logic  sel_bad;
  logic  unused_fields;

  assign sel = csel_e'(insn[F_CSEL +: CSEL_W]);

  always_comb begin
    case (sel)
      CSEL_FULL, CSEL_LOW, CSEL_HIGH, CSEL_BB: sel_bad = 1'b0;
      default:                                 sel_bad = 1'b1;
    endcase
  end

  always_comb begin
    ctl.dst   = insn[F_DST +: REG_W];
    ctl.imm   = insn[F_IMM +: HALF_W];
    ctl.a_hi  = insn[F_AHI];
    ctl.a_sgn = insn[F_ASGN];
    ctl.b_sgn = insn[F_BSGN];
    ctl.shl   = insn[F_SHL];
    ctl.mrg   = insn[F_MRG];
    ctl.csel  = sel;
    ctl.unsup = insn[F_EXT] | insn[F_CC] | sel_bad;
  end

  // register-index fields and spare bits are consumed elsewhere
  assign unused_fields = ^{insn[F_IMM-1:REG_W], insn[F_CC-1:F_EXT+1],
                           insn[INSN_W-1:F_AHI+1]};

endmodule

// File: rtl/hmad_half_ext.sv
module hmad_half_ext #(
  parameter int DATA_W = 32,
  parameter int HALF_W = 16
) (
  input  logic [DATA_W-1:0] src,
  input  logic              hi,
  input  logic              sgn,
  output logic [DATA_W-1:0] ext
);

  localparam int PAD_W = DATA_W - HALF_W;

  logic [HALF_W-1:0] half;

  assign half = hi ? src[DATA_W-1 -: HALF_W] : src[HALF_W-1:0];
  assign ext  = sgn ? {{PAD_W{half[HALF_W-1]}}, half} : {{PAD_W{1'b0}}, half};

endmodule

// File: rtl/hmad_stage1.sv
module hmad_stage1
  import hmad_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int HW = HALF_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  ctl_t          ctl,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] c,
  output logic          s1_valid,
  output logic [REG_W-1:0] s1_dst,
  output logic [HW-1:0] s1_imm,
  output logic          s1_shl,
  output logic          s1_mrg,
  output logic          s1_unsup,
  output logic [DW-1:0] s1_prod,
  output logic [DW-1:0] s1_add
);

  localparam int PAD_W = DW - HW;

  logic [DW-1:0] a_ext;
  logic [DW-1:0] b_ext;
  logic [DW-1:0] b_src;
  logic [DW-1:0] prod;
  logic [DW-1:0] addend;

  assign b_src = {{PAD_W{1'b0}}, ctl.imm};

  hmad_half_ext #(.DATA_W(DW), .HALF_W(HW)) u_ext_a (
    .src(a), .hi(ctl.a_hi), .sgn(ctl.a_sgn), .ext(a_ext)
  );

  hmad_half_ext #(.DATA_W(DW), .HALF_W(HW)) u_ext_b (
    .src(b_src), .hi(1'b0), .sgn(ctl.b_sgn), .ext(b_ext)
  );

  assign prod = a_ext * b_ext;

  always_comb begin
    case (ctl.csel)
      CSEL_FULL: addend = c;
      CSEL_LOW:  addend = {{PAD_W{1'b0}}, c[HW-1:0]};
      CSEL_HIGH: addend = {{PAD_W{1'b0}}, c[DW-1 -: HW]};
      CSEL_BB:   addend = {ctl.imm, ctl.imm};
      default:   addend = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= in_valid;
    end
    s1_dst   <= ctl.dst;
    s1_imm   <= ctl.imm;
    s1_shl   <= ctl.shl;
    s1_mrg   <= ctl.mrg;
    s1_unsup <= ctl.unsup;
    s1_prod  <= prod;
    s1_add   <= addend;
  end

  // R8: every accepted instruction occupies stage 1 on the next cycle
  a_r8_stage1_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> s1_valid);

  // R5: the low-half addend never carries bits above the half
  a_r5_low_addend: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ctl.csel == CSEL_LOW) |=> (s1_add[DW-1:HW] == '0));

endmodule

// File: rtl/hmad_stage2.sv
module hmad_stage2
  import hmad_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int HW = HALF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s1_valid,
  input  logic [REG_W-1:0] s1_dst,
  input  logic [HW-1:0]    s1_imm,
  input  logic             s1_shl,
  input  logic             s1_mrg,
  input  logic             s1_unsup,
  input  logic [DW-1:0]    s1_prod,
  input  logic [DW-1:0]    s1_add,
  output logic             out_valid,
  output logic [REG_W-1:0] out_dst,
  output logic [DW-1:0]    out_result,
  output logic             out_wr_en,
  output logic             out_unsup
);

  logic [DW-1:0] shifted;
  logic [DW-1:0] sum;
  logic [DW-1:0] merged;

  assign shifted = s1_shl ? (s1_prod << HW) : s1_prod;
  assign sum     = shifted + s1_add;
  assign merged  = s1_mrg ? {s1_imm, sum[HW-1:0]} : sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_wr_en <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      out_wr_en <= s1_valid & ~s1_unsup;
    end
    out_dst    <= s1_dst;
    out_result <= merged;
    out_unsup  <= s1_unsup;
  end

  // R8: stage 1 content reaches the output on the next cycle
  a_r8_stage2_follow: assert property (@(posedge clk) disable iff (rst)
    s1_valid |=> out_valid);

  // R6: merged beats carry B in the upper half
  a_r6_merge_upper: assert property (@(posedge clk) disable iff (rst)
    (s1_valid && s1_mrg) |=> (out_result[DW-1:HW] == $past(s1_imm)));

  // R7: an unsupported beat never writes
  a_r7_no_write: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_unsup) |-> !out_wr_en);

  // R7: a write only happens on a present beat
  a_r7_write_has_beat: assert property (@(posedge clk) disable iff (rst)
    out_wr_en |-> out_valid);

endmodule

// File: rtl/hmad_unit.sv
module hmad_unit
  import hmad_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_c,
  output logic              out_valid,
  output logic [REG_W-1:0]  out_dst,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wr_en,
  output logic              out_unsup
);

  ctl_t              ctl;
  logic              s1_valid;
  logic [REG_W-1:0]  s1_dst;
  logic [HALF_W-1:0] s1_imm;
  logic              s1_shl;
  logic              s1_mrg;
  logic              s1_unsup;
  logic [DATA_W-1:0] s1_prod;
  logic [DATA_W-1:0] s1_add;

  hmad_decode u_decode (
    .insn (in_insn),
    .ctl  (ctl)
  );

  hmad_stage1 #(.DW(DATA_W), .HW(HALF_W)) u_s1 (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .ctl      (ctl),
    .a        (in_a),
    .c        (in_c),
    .s1_valid (s1_valid),
    .s1_dst   (s1_dst),
    .s1_imm   (s1_imm),
    .s1_shl   (s1_shl),
    .s1_mrg   (s1_mrg),
    .s1_unsup (s1_unsup),
    .s1_prod  (s1_prod),
    .s1_add   (s1_add)
  );

  hmad_stage2 #(.DW(DATA_W), .HW(HALF_W)) u_s2 (
    .clk        (clk),
    .rst        (rst),
    .s1_valid   (s1_valid),
    .s1_dst     (s1_dst),
    .s1_imm     (s1_imm),
    .s1_shl     (s1_shl),
    .s1_mrg     (s1_mrg),
    .s1_unsup   (s1_unsup),
    .s1_prod    (s1_prod),
    .s1_add     (s1_add),
    .out_valid  (out_valid),
    .out_dst    (out_dst),
    .out_result (out_result),
    .out_wr_en  (out_wr_en),
    .out_unsup  (out_unsup)
  );

  // R1: the destination index travels with its instruction
  a_r1_dst_carry: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (s1_dst == $past(in_insn[F_DST +: REG_W])));

  // R7: reserved addend codes are flagged
  a_r7_rsv_code: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_insn[F_CSEL +: CSEL_W] == 3'd3) |=> s1_unsup);

endmodule

// File: tb/hmad_unit_tb.sv
module hmad_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_insn = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_c = '0;
  string       in_tag = "idle";

  logic        out_valid;
  logic [7:0]  out_dst;
  logic [31:0] out_result;
  logic        out_wr_en;
  logic        out_unsup;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hmad_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_insn(in_insn),
    .in_a(in_a), .in_c(in_c), .out_valid(out_valid), .out_dst(out_dst),
    .out_result(out_result), .out_wr_en(out_wr_en), .out_unsup(out_unsup)
  );

  function automatic logic [63:0] mk(input logic [7:0] d, input logic [15:0] b,
      input bit shl, input bit mrg, input bit ext, input bit cc,
      input bit as, input bit bs, input logic [2:0] mode, input bit ah);
    logic [63:0] w;
    w = '0;
    w[7:0]   = d;
    w[15:8]  = 8'h21;
    w[35:20] = b;
    w[36]    = shl;
    w[37]    = mrg;
    w[38]    = ext;
    w[46:39] = 8'h37;
    w[47]    = cc;
    w[48]    = as;
    w[49]    = bs;
    w[52:50] = mode;
    w[53]    = ah;
    return w;
  endfunction

  function automatic bit ref_unsup(input logic [63:0] w);
    int m;
    m = int'(w[52:50]);
    return w[38] || w[47] || m == 3 || m > 4;
  endfunction

  function automatic logic [31:0] ref_result(input logic [63:0] w,
      input logic [31:0] a, input logic [31:0] c);
    logic [15:0] ah, b;
    longint av, bv, p, r;
    ah = w[53] ? a[31:16] : a[15:0];
    b  = w[35:20];
    av = w[48] ? longint'($signed(ah)) : longint'(ah);
    bv = w[49] ? longint'($signed(b)) : longint'(b);
    p  = (av * bv) & 64'hFFFF_FFFF;
    if (w[36]) p = (p * 65536) & 64'hFFFF_FFFF;
    case (int'(w[52:50]))
      0: r = longint'(c);
      1: r = longint'(c[15:0]);
      2: r = longint'(c[31:16]);
      4: r = longint'(b) * 65536 + longint'(b);
      default: r = 0;
    endcase
    r = (p + r) & 64'hFFFF_FFFF;
    if (w[37]) r = (longint'(b) * 65536) + (r & 64'hFFFF);
    return r[31:0];
  endfunction

  // behavioural two-cycle reference
  logic        m_rst = 1'b1;
  logic        m1v = 1'b0, m2v = 1'b0;
  logic [7:0]  m1d, m2d;
  logic [31:0] m1r, m2r;
  bit          m1u, m2u;
  string       m1t, m2t;

  always @(posedge clk) begin
    m_rst <= rst;
    if (rst) begin
      m1v <= 1'b0;
      m2v <= 1'b0;
    end else begin
      m1v <= in_valid;
      m1d <= in_insn[7:0];
      m1r <= ref_result(in_insn, in_a, in_c);
      m1u <= ref_unsup(in_insn);
      m1t <= in_tag;
      m2v <= m1v;
      m2d <= m1d;
      m2r <= m1r;
      m2u <= m1u;
      m2t <= m1t;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (m_rst) begin
        chk(out_valid == 1'b0, "R9 valid cleared by reset", 32'(out_valid), 32'd0);
      end else begin
        chk(out_valid == m2v, {"R8 beat timing ", m2t}, 32'(out_valid), 32'(m2v));
        if (m2v) begin
          chk(out_dst == m2d, {"R1 dst ", m2t}, 32'(out_dst), 32'(m2d));
          chk(out_unsup == m2u, {"R7 flag ", m2t}, 32'(out_unsup), 32'(m2u));
          chk(out_wr_en == !m2u, {"R7 wr_en ", m2t}, 32'(out_wr_en), 32'(!m2u));
          if (!m2u)
            chk(out_result == m2r, {"result ", m2t}, out_result, m2r);
        end
      end
    end
  end

  task automatic issue(input string tag, input logic [63:0] w,
                       input logic [31:0] a, input logic [31:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_insn  = w;
    in_a     = a;
    in_c     = c;
    in_tag   = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_insn  = $urandom();
      in_tag   = "idle";
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] ca;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);
    ca = 32'hAAAA_5555;

    // R2 half select and sign fill of A
    issue("R2 low half signed",   mk(8'h01, 16'h0002, 0,0,0,0, 1,0, 3'd1, 0), 32'h8001_F003, 32'h0);
    issue("R2 high half signed",  mk(8'h02, 16'h0002, 0,0,0,0, 1,0, 3'd1, 1), 32'h8001_7FFF, 32'h0);
    issue("R2 high half zero",    mk(8'h03, 16'h0002, 0,0,0,0, 0,0, 3'd1, 1), 32'h8001_7FFF, 32'h0);
    issue("R2 low half zero",     mk(8'h04, 16'h0003, 0,0,0,0, 0,0, 3'd1, 0), 32'h8001_F003, 32'h0);
    // R3 B fill
    issue("R3 B signed",          mk(8'h05, 16'hFFFF, 0,0,0,0, 0,1, 3'd1, 0), 32'h0000_0003, 32'h0);
    issue("R3 B zero",            mk(8'h06, 16'hFFFF, 0,0,0,0, 0,0, 3'd1, 0), 32'h0000_0003, 32'h0);
    issue("R3 both signed",       mk(8'h07, 16'h8000, 0,0,0,0, 1,1, 3'd1, 0), 32'h0000_8000, 32'h0);
    // R4 truncation and shift
    issue("R4 full width",        mk(8'h08, 16'hFFFF, 0,0,0,0, 0,0, 3'd1, 0), 32'h0000_FFFF, 32'h0);
    issue("R4 shifted",           mk(8'h09, 16'h0010, 1,0,0,0, 0,0, 3'd1, 0), 32'h0000_1234, 32'h0);
    issue("R4 shifted wrap",      mk(8'h0A, 16'hFFFF, 1,0,0,0, 0,0, 3'd0, 0), 32'h0000_FFFF, ca);
    // R5 addend codes
    issue("R5 code0 full C",      mk(8'h10, 16'h0100, 0,0,0,0, 0,0, 3'd0, 0), 32'h0000_0101, ca);
    issue("R5 code1 low C",       mk(8'h11, 16'h0100, 0,0,0,0, 0,0, 3'd1, 0), 32'h0000_0101, ca);
    issue("R5 code2 high C",      mk(8'h12, 16'h0100, 0,0,0,0, 0,0, 3'd2, 0), 32'h0000_0101, ca);
    issue("R5 code4 B pair",      mk(8'h13, 16'h1357, 0,0,0,0, 0,0, 3'd4, 0), 32'h0000_0101, ca);
    issue("R5 wrap modulo",       mk(8'h14, 16'hFFFF, 0,0,0,0, 0,0, 3'd0, 0), 32'h0000_FFFF, 32'hFFFF_FFFF);
    // R6 merge
    issue("R6 merge",             mk(8'h20, 16'hBEEF, 0,1,0,0, 0,0, 3'd0, 0), 32'h0000_0011, ca);
    issue("R6 merge shifted",     mk(8'h21, 16'h00C3, 1,1,0,0, 1,1, 3'd2, 1), 32'hF00F_0000, ca);
    idle(1);
    // R7 unsupported encodings
    issue("R7 extended flag",     mk(8'h30, 16'h0001, 0,0,1,0, 0,0, 3'd0, 0), 32'h1, ca);
    issue("R7 cc flag",           mk(8'h31, 16'h0001, 0,0,0,1, 0,0, 3'd0, 0), 32'h1, ca);
    issue("R7 code3",             mk(8'h32, 16'h0001, 0,0,0,0, 0,0, 3'd3, 0), 32'h1, ca);
    issue("R7 code5",             mk(8'h33, 16'h0001, 0,0,0,0, 0,0, 3'd5, 0), 32'h1, ca);
    issue("R7 code6",             mk(8'h34, 16'h0001, 0,0,0,0, 0,0, 3'd6, 0), 32'h1, ca);
    issue("R7 code7",             mk(8'h35, 16'h0001, 0,0,0,0, 0,0, 3'd7, 0), 32'h1, ca);
    issue("R7 supported after",   mk(8'h36, 16'h0002, 0,0,0,0, 0,0, 3'd0, 0), 32'h5, ca);
    idle(3);

    // R9 reset with instructions in flight
    issue("R9 before reset a",    mk(8'h40, 16'h0005, 0,0,0,0, 0,0, 3'd0, 0), 32'h7, ca);
    issue("R9 before reset b",    mk(8'h41, 16'h0006, 0,0,0,0, 0,0, 3'd0, 0), 32'h7, ca);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    issue("R9 after reset",       mk(8'h42, 16'h0009, 0,0,0,0, 0,0, 3'd0, 0), 32'h3, ca);
    idle(3);

    // R8 random traffic with gaps
    for (int i = 0; i < 600; i++) begin
      logic [63:0] w;
      w = {$urandom(), $urandom()};
      if (($urandom() & 1) != 0) begin
        w[38] = 1'b0;
        w[47] = 1'b0;
      end
      if (($urandom() % 5) == 0) idle(1);
      issue("R8 random", w, $urandom(), $urandom());
    end
    idle(4);
    finish_run();
  end

endmodule